// File: doc/BRIEF.md
# Short-Float Rate Value Codec

This block converts between a wide unsigned integer and a compact 12-bit short-float. The short-float has an 8-bit mantissa field and a 4-bit exponent field, both unsigned. It carries a hidden leading one and no exponent bias. Such codes suit rate and burst settings, where only the leading bits of a large number matter.

The encoder is a normalising shifter that runs over several cycles, with a start strobe and a one-cycle done pulse. It first scales the integer up by 256. It then halves the working value once per clock until the value fits in 9 bits, counting each halving in the exponent. The mantissa is whatever remains below the leading one. Dropped bits are discarded, so the result truncates and never rounds.

The decoder takes a code and returns the rebuilt integer on the next clock. It places a one above the mantissa, shifts that left by the exponent, and shifts right by 8. Encoding and decoding are independent and may be used in the same cycle.

Top module: `sf_codec`

## Requirements
- R1: For a decode request with mantissa m and exponent e, the decoded value equals ((256 + m) * 2^e) / 256, truncated. The value is 16 bits wide; code (0,0) gives 1 and code (255,15) gives 65408.
- R2: `dec_vld` is high exactly in the cycle after a cycle with `dec_req` high, and low otherwise. `dec_value` is valid while `dec_vld` is high.
- R3: For a nonzero input whose highest set bit is at position p, with p at most 15, encoding returns exponent p and a mantissa equal to the 8 bits directly below that leading one. Lower bits are dropped without rounding.
- R4: `enc_done` is a one-cycle pulse. It rises min(p,15)+1 clock edges after the edge that accepted `enc_start`; for an input of zero it rises after 1 edge.
- R5: `enc_busy` is high from the edge that accepts a start until the edge that completes the encode. A start raised while busy is ignored, and the running encode keeps its original operand.
- R6: If the input needs more than 15 halvings (p of 16 or more), the encode saturates to mantissa 255 and exponent 15, raises `enc_ovf`, and completes after 16 edges.
- R7: An input of zero encodes to mantissa 0 and exponent 0 with `enc_unf` high. `enc_unf` is low for every nonzero input, and `enc_ovf` is low for every non-saturating input.
- R8: After reset, `enc_busy`, `enc_done`, `dec_vld`, `enc_ovf`, `enc_unf`, `enc_mant` and `enc_exp` are all zero.
- R9: The encode outputs (`enc_mant`, `enc_exp`, `enc_ovf`, `enc_unf`) change only on the edge that raises `enc_done`, and hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_start | input | 1 | Start strobe for an encode; taken only when idle |
| enc_in | input | 64 | Unsigned integer to encode |
| enc_busy | output | 1 | Encoder is normalising |
| enc_done | output | 1 | One-cycle pulse when the encode result is updated |
| enc_mant | output | 8 | Encoded mantissa, hidden one removed |
| enc_exp | output | 4 | Encoded exponent |
| enc_ovf | output | 1 | Last encode saturated |
| enc_unf | output | 1 | Last encode had a zero input |
| dec_req | input | 1 | Decode request |
| dec_mant | input | 8 | Mantissa to decode |
| dec_exp | input | 4 | Exponent to decode |
| dec_vld | output | 1 | Decoded value valid |
| dec_value | output | 16 | Rebuilt integer |

## Verification
An encode may complete in the same cycle that the decoder presents a result, and the two paths must not disturb each other there. While every encode is in flight, the bench issues a random decode request, or leaves one out, on each clock. These requests run through the completion cycle, so decode results and done pulses coincide on many runs. Each decode value and each encode result is compared against separate bench arithmetic in that same cycle.

// File: rtl/sf_codec_pkg.sv
package sf_codec_pkg;
  typedef enum logic {
    ENC_IDLE = 1'b0,
    ENC_RUN  = 1'b1
  } enc_phase_e;
endpackage

// File: rtl/sf_enc_core.sv
module sf_enc_core
  import sf_codec_pkg::*;
#(
  parameter int INT_W  = 64,
  parameter int MANT_W = 8,
  parameter int EXP_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [INT_W-1:0]  din,
  output logic              busy,
  output logic              done,
  output logic [MANT_W-1:0] mant,
  output logic [EXP_W-1:0]  expo,
  output logic              ovf,
  output logic              unf,
  output logic              sat_evt
);
  localparam int WORK_W = INT_W + MANT_W;
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  // working value exceeds the 9-bit normalised window
  function automatic logic too_wide(input logic [WORK_W-1:0] w);
    return |w[WORK_W-1:MANT_W+1];
  endfunction

  enc_phase_e        phase_q;
  logic [WORK_W-1:0] work_q;
  logic [EXP_W-1:0]  cnt_q;
  logic              zero_q;
  logic              done_q;
  logic [MANT_W-1:0] mant_q;
  logic [EXP_W-1:0]  exp_q;
  logic              ovf_q;
  logic              unf_q;

  logic running, over, step_sat, step_shift, step_finish, accept;

  assign running     = (phase_q == ENC_RUN);
  assign over        = too_wide(work_q);
  assign step_sat    = running && over && (cnt_q == EXP_MAX);
  assign step_shift  = running && over && !step_sat;
  assign step_finish = running && !step_shift;
  assign accept      = !running && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= ENC_IDLE;
      work_q  <= '0;
      cnt_q   <= '0;
      zero_q  <= 1'b0;
      done_q  <= 1'b0;
      mant_q  <= '0;
      exp_q   <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (step_shift) begin
        work_q <= work_q >> 1;
        cnt_q  <= cnt_q + 1'b1;
      end else if (step_finish) begin
        phase_q <= ENC_IDLE;
        done_q  <= 1'b1;
        if (step_sat) begin
          mant_q <= {MANT_W{1'b1}};
          exp_q  <= EXP_MAX;
          ovf_q  <= 1'b1;
          unf_q  <= 1'b0;
        end else begin
          mant_q <= work_q[MANT_W-1:0];
          exp_q  <= cnt_q;
          ovf_q  <= 1'b0;
          unf_q  <= zero_q;
        end
      end else if (accept) begin
        phase_q <= ENC_RUN;
        work_q  <= {din, {MANT_W{1'b0}}};
        cnt_q   <= '0;
        zero_q  <= (din == '0);
      end
    end
  end

  assign busy    = running;
  assign done    = done_q;
  assign mant    = mant_q;
  assign expo    = exp_q;
  assign ovf     = ovf_q;
  assign unf     = unf_q;
  assign sat_evt = step_sat;
endmodule

// File: rtl/sf_dec_core.sv
module sf_dec_core #(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 4,
  parameter int DEC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  expo,
  output logic              vld,
  output logic [DEC_W-1:0]  value
);
  localparam int WIDE_W = MANT_W + DEC_W;

  function automatic logic [DEC_W-1:0] expand(input logic [MANT_W-1:0] m,
                                              input logic [EXP_W-1:0]  e);
    logic [WIDE_W-1:0] wide;
    wide = {{(DEC_W-1){1'b0}}, 1'b1, m} << e;
    return wide[MANT_W +: DEC_W];
  endfunction

  logic             vld_q;
  logic [DEC_W-1:0] value_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= 1'b0;
      value_q <= '0;
    end else begin
      vld_q <= req;
      if (req) value_q <= expand(mant, expo);
    end
  end

  assign vld   = vld_q;
  assign value = value_q;
endmodule

// File: rtl/sf_codec.sv
module sf_codec #(
  parameter int INT_W  = 64,
  parameter int MANT_W = 8,
  parameter int EXP_W  = 4,
  parameter int DEC_W  = 1 << EXP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_start,
  input  logic [INT_W-1:0]  enc_in,
  output logic              enc_busy,
  output logic              enc_done,
  output logic [MANT_W-1:0] enc_mant,
  output logic [EXP_W-1:0]  enc_exp,
  output logic              enc_ovf,
  output logic              enc_unf,
  input  logic              dec_req,
  input  logic [MANT_W-1:0] dec_mant,
  input  logic [EXP_W-1:0]  dec_exp,
  output logic              dec_vld,
  output logic [DEC_W-1:0]  dec_value
);
  logic enc_sat_evt;

  sf_enc_core #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_enc (
    .clk(clk), .rst(rst), .start(enc_start), .din(enc_in),
    .busy(enc_busy), .done(enc_done), .mant(enc_mant), .expo(enc_exp),
    .ovf(enc_ovf), .unf(enc_unf), .sat_evt(enc_sat_evt)
  );

  sf_dec_core #(.MANT_W(MANT_W), .EXP_W(EXP_W), .DEC_W(DEC_W)) u_dec (
    .clk(clk), .rst(rst), .req(dec_req), .mant(dec_mant), .expo(dec_exp),
    .vld(dec_vld), .value(dec_value)
  );
endmodule

// File: rtl/sf_codec_chk.sv
module sf_codec_chk #(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 4,
  parameter int DEC_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              enc_busy,
  input logic              enc_done,
  input logic [MANT_W-1:0] enc_mant,
  input logic [EXP_W-1:0]  enc_exp,
  input logic              enc_ovf,
  input logic              enc_unf,
  input logic              enc_sat_evt,
  input logic              dec_req,
  input logic              dec_vld,
  input logic [DEC_W-1:0]  dec_value
);
  // R4: done lasts one cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    enc_done |=> !enc_done);
  // R5: completion ends the busy window
  p_busy_done_r5: assert property (@(posedge clk) disable iff (rst)
    enc_done |-> (!enc_busy && $past(enc_busy)));
  // R6: saturation event yields the maximum code
  p_sat_code_r6: assert property (@(posedge clk) disable iff (rst)
    enc_sat_evt |=> (enc_done && enc_ovf && (&enc_mant) && (&enc_exp)));
  // R7: zero-input flag carries the minimum code
  p_unf_code_r7: assert property (@(posedge clk) disable iff (rst)
    (enc_done && enc_unf) |-> (enc_mant == '0 && enc_exp == '0 && !enc_ovf));
  // R2: decode valid follows a request
  p_dec_vld_r2: assert property (@(posedge clk) disable iff (rst)
    dec_req |=> dec_vld);
  p_dec_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !dec_req |=> !dec_vld);
  // R1: hidden one guarantees a nonzero decode
  p_dec_nonzero_r1: assert property (@(posedge clk) disable iff (rst)
    dec_vld |-> (dec_value != '0));
  // R9: results hold between completions
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !enc_done |-> ($stable(enc_mant) && $stable(enc_exp) && $stable(enc_ovf) && $stable(enc_unf)));
endmodule

bind sf_codec sf_codec_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W), .DEC_W(DEC_W)) u_chk (
  .clk(clk), .rst(rst), .enc_busy(enc_busy), .enc_done(enc_done),
  .enc_mant(enc_mant), .enc_exp(enc_exp), .enc_ovf(enc_ovf), .enc_unf(enc_unf),
  .enc_sat_evt(enc_sat_evt), .dec_req(dec_req), .dec_vld(dec_vld), .dec_value(dec_value)
);

// File: tb/sf_codec_bench.sv
module sf_codec_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enc_start = 1'b0;
  logic [63:0] enc_in = '0;
  logic        enc_busy, enc_done, enc_ovf, enc_unf, dec_vld;
  logic [7:0]  enc_mant;
  logic [3:0]  enc_exp;
  logic        dec_req = 1'b0;
  logic [7:0]  dec_mant = '0;
  logic [3:0]  dec_exp = '0;
  logic [15:0] dec_value;

  int errors = 0;
  int checks = 0;

  // pending decode expectation
  bit          pend = 1'b0;
  logic [15:0] pend_val = '0;

  always #4 clk = ~clk;

  sf_codec u_sf_codec (
    .clk(clk), .rst(rst), .enc_start(enc_start), .enc_in(enc_in),
    .enc_busy(enc_busy), .enc_done(enc_done), .enc_mant(enc_mant), .enc_exp(enc_exp),
    .enc_ovf(enc_ovf), .enc_unf(enc_unf), .dec_req(dec_req), .dec_mant(dec_mant),
    .dec_exp(dec_exp), .dec_vld(dec_vld), .dec_value(dec_value)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [15:0] model_dec(input logic [7:0] m, input logic [3:0] e);
    longint v;
    v = (longint'(256 + m) * (longint'(1) << e)) / 256;
    return v[15:0];
  endfunction

  task automatic model_enc(input logic [63:0] x, output int lat, output logic [7:0] m,
                           output logic [3:0] e, output bit ov, output bit un);
    int p = 0;
    logic [71:0] w;
    for (int i = 0; i < 64; i++) if (x[i]) p = i;
    un = (x == 0); ov = 1'b0;
    if (x == 0) begin lat = 1; m = 0; e = 0; end
    else if (p > 15) begin lat = 16; m = 8'hFF; e = 4'hF; ov = 1'b1; end
    else begin
      w = {x, 8'h00} >> p;
      m = w[7:0]; e = p[3:0]; lat = p + 1;
    end
  endtask

  // called at a negedge: judge the previous request, then drive a new one
  task automatic dec_step(input bit rq, input logic [7:0] m, input logic [3:0] e);
    if (pend) begin
      check(dec_vld == 1'b1, "R2 dec_vld after request", dec_vld, 1);
      check(dec_value == pend_val, "R1 decoded value", dec_value, pend_val);
    end else
      check(dec_vld == 1'b0, "R2 dec_vld idle", dec_vld, 0);
    dec_req = rq; dec_mant = m; dec_exp = e;
    pend = rq; pend_val = model_dec(m, e);
  endtask

  task automatic run_enc(input logic [63:0] x, input bit poke);
    int lat, k;
    logic [7:0] m; logic [3:0] e; bit ov, un;
    logic [7:0] old_m; logic [3:0] old_e;
    model_enc(x, lat, m, e, ov, un);
    old_m = enc_mant; old_e = enc_exp;
    @(negedge clk);
    enc_start = 1'b1; enc_in = x;
    dec_step($urandom_range(1, 0) == 1, 8'($urandom), 4'($urandom));
    @(negedge clk);
    check(enc_busy == 1'b1, "R5 busy after start", enc_busy, 1);
    if (poke) begin enc_in = ~x; enc_start = 1'b1; end   // R5: must be ignored
    else enc_start = 1'b0;
    k = 0;
    while (!enc_done && k < 40) begin
      check(enc_busy == 1'b1, "R5 busy during encode", enc_busy, 1);
      check(enc_mant == old_m && enc_exp == old_e, "R9 result held", enc_mant, old_m);
      dec_step($urandom_range(1, 0) == 1, 8'($urandom), 4'($urandom));
      @(negedge clk);
      enc_start = 1'b0;
      k++;
    end
    check(k == lat, "R4 done latency", k, lat);
    check(enc_busy == 1'b0, "R5 busy cleared at done", enc_busy, 0);
    check(enc_mant == m, "R3 mantissa", enc_mant, m);
    check(enc_exp == e, "R3 exponent", enc_exp, e);
    check(enc_ovf == ov, "R6 overflow flag", enc_ovf, ov);
    check(enc_unf == un, "R7 underflow flag", enc_unf, un);
    dec_step(1'b1, enc_mant, enc_exp);
    @(negedge clk);
    check(enc_done == 1'b0, "R4 done one cycle", enc_done, 0);
    check(enc_mant == m && enc_exp == e, "R9 result kept", enc_mant, m);
    dec_step(1'b0, 8'h00, 4'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] x;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    check(enc_busy == 0 && enc_done == 0, "R8 control idle", {enc_busy, enc_done}, 0);
    check(dec_vld == 0 && enc_ovf == 0 && enc_unf == 0, "R8 flags clear", {dec_vld, enc_ovf, enc_unf}, 0);
    check(enc_mant == 0 && enc_exp == 0, "R8 code clear", {enc_exp, enc_mant}, 0);
    // R1 directed extremes
    dec_step(1'b1, 8'h00, 4'h0); @(negedge clk);
    dec_step(1'b1, 8'hFF, 4'hF); @(negedge clk);
    check(dec_value == 16'd65408, "R1 maximum code", dec_value, 65408);
    dec_step(1'b0, 8'h00, 4'h0); @(negedge clk);
    dec_step(1'b0, 8'h00, 4'h0);
    // directed encodes: zero (R7), one, boundaries, overflow (R6)
    run_enc(64'd0, 1'b1);
    run_enc(64'd1, 1'b0);
    run_enc(64'd511, 1'b0);
    run_enc(64'd65535, 1'b0);
    run_enc(64'd65536, 1'b1);
    run_enc(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    run_enc(64'd300, 1'b1);
    for (int n = 0; n < 300; n++) begin
      x = {$urandom, $urandom};
      x = x >> $urandom_range(63, 40);
      run_enc(x, ($urandom_range(3, 0) == 0));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule